// File: doc/BRIEF.md
# Character Display Controller Core

This block is the controller that sits inside a character display module and answers a host. The host issues single-cycle register accesses. The register-select pin picks the command path or the data path, and the read/write pin picks the direction. A command byte is decoded by its highest set bit. Data accesses go to an 80-byte text memory or to a 64-byte glyph-pattern memory. One 7-bit address pointer serves both memories, and every data access moves it one step up or down. Each accepted command or data access holds a busy flag for a parameterised number of cycles. While the flag is high, further writes and data reads are dropped. A status read is always served.

The port has no valid/ready handshake and no back-pressure. A strobe is sampled on exactly one clock edge. The host is expected to poll the status byte, or to wait out the documented busy time, before its next access. An access that arrives early is lost and is not queued. A second, combinational read port lets a display engine fetch the byte behind any raw text address. The mode outputs carry the current configuration and the horizontal display offset.

Top module: `chardisp_ctrl`

## Requirements
- R1: A read with rs=0 and rw=1 returns {busy, address[6:0]} on rdata one cycle after the strobe. It is served even while busy, and it never starts a busy period.
- R2: A command byte is decoded by its highest set bit:
  - bit 7: text address (bits 6:0).
  - bit 6: pattern address (bits 5:0).
  - bit 5: configuration: bit 4 bus8, bit 3 lines2, bit 2 font_tall.
  - bit 4: move/shift: bit 3 selects display shift (1) or cursor move (0), bit 2 selects right (1) or left (0).
  - bit 3: display control: bit 2 on, bit 1 cursor, bit 0 blink.
  - bit 2: entry mode: bit 1 increment, bit 0 auto-shift.
  - bit 1: home.
  - bit 0: clear.
- R3: An accepted clear or home raises busy for LONG_CYCLES cycles, starting the cycle after the strobe. Any other accepted command, data write or data read raises it for SHORT_CYCLES cycles.
- R4: Clear writes BLANK_CODE into every text location, sets the address to 0, sets the increment bit to 1, zeroes the offset and selects text memory.
- R5: Home sets the address to 0 and the offset to 0, selects text memory and leaves memory contents unchanged.
- R6: With lines2=1, the valid text addresses are 0x00–0x27 and 0x40–0x67. Stepping up goes 0x27→0x40 and 0x67→0x00. Stepping down goes 0x40→0x27 and 0x00→0x67. The view port returns 0 for an invalid address.
- R7: With lines2=0, the text addresses are 0x00–0x4F. Stepping wraps 0x4F→0x00 going up and 0x00→0x4F going down.
- R8: A write (rs=0 or rs=1) that arrives while busy is high changes neither the address, nor the memories, nor the modes.
- R9: Data accesses target the memory chosen by the most recent address command. Pattern addresses wrap within 6 bits.
- R10: A move/shift command with the shift bit set changes the offset: left adds 1 and right subtracts 1, modulo 40. With the shift bit clear, it steps the address up (right) or down (left) and touches no memory.
- R11: With auto-shift on, a text data write also moves the offset: up by 1 when the increment bit is set, down by 1 when it is clear.
- R12: A wr_strobe with rw=1 is ignored. An rd_strobe with rw=0 is also ignored.
- R13: Reset leaves the address at 0, the text memory at BLANK_CODE, the increment bit at 1, all other mode bits and the offset at 0, and busy low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rs | input | 1 | 0 selects the command/status path, 1 selects the data path |
| rw | input | 1 | 1 marks a read, 0 marks a write |
| wr_strobe | input | 1 | One-cycle write request |
| rd_strobe | input | 1 | One-cycle read request |
| wdata | input | 8 | Command or data byte |
| rdata | output | 8 | Registered read result |
| busy | output | 1 | Execution in progress |
| view_addr | input | 7 | Raw text address for the display fetch port |
| view_data | output | 8 | Text byte at view_addr |
| mode_incr | output | 1 | Address steps up after data access |
| mode_autoshift | output | 1 | Display shifts on text writes |
| disp_on | output | 1 | Display enabled |
| cursor_on | output | 1 | Cursor shown |
| blink_on | output | 1 | Cursor blinks |
| bus8 | output | 1 | 8-bit bus width flag |
| lines2 | output | 1 | Two-line addressing |
| font_tall | output | 1 | Tall font flag |
| disp_offset | output | 6 | Horizontal display offset, 0–39 |

## Verification
The bench builds the block with LONG_CYCLES=12 and SHORT_CYCLES=3. With these values every busy period can be counted cycle by cycle. An address sweep through all 80 text locations then finishes in a few thousand cycles. This makes it practical to walk the whole two-line address ring, reading the pointer back after every write, and to check all 128 raw view addresses after each fill and after a clear. Both wrap points are also exercised in both directions, in both line modes.

// File: rtl/chardisp_pkg.sv
package chardisp_pkg;
  localparam int unsigned DD_BYTES = 80;
  localparam int unsigned LINE_LEN = 40;
  localparam int unsigned CG_BYTES = 64;
  localparam logic [6:0] L1_LAST  = 7'h27;
  localparam logic [6:0] L2_FIRST = 7'h40;
  localparam logic [6:0] L2_LAST  = 7'h67;
  localparam logic [6:0] FLAT_LAST = 7'(DD_BYTES - 1);

  typedef enum logic [3:0] {
    OP_NONE, OP_CLEAR, OP_HOME, OP_ENTRY, OP_DISP,
    OP_MOVE, OP_CONFIG, OP_CGADDR, OP_DDADDR
  } op_e;

  // Next text address in the chosen direction and line mode.
  function automatic logic [6:0] dd_next(input logic [6:0] a, input logic up,
                                         input logic two);
    if (two) begin
      if (up) begin
        if (a == L1_LAST) return L2_FIRST;
        if (a == L2_LAST) return 7'h00;
        return a + 7'd1;
      end
      if (a == L2_FIRST) return L1_LAST;
      if (a == 7'h00) return L2_LAST;
      return a - 7'd1;
    end
    if (up) return (a >= FLAT_LAST) ? 7'h00 : a + 7'd1;
    return (a == 7'h00) ? FLAT_LAST : a - 7'd1;
  endfunction

  function automatic logic dd_ok(input logic [6:0] a, input logic two);
    if (two) return a[5:0] < 6'(LINE_LEN);
    return a < 7'(DD_BYTES);
  endfunction

  function automatic logic [6:0] dd_idx(input logic [6:0] a, input logic two);
    if (two && a[6]) return 7'(LINE_LEN) + {1'b0, a[5:0]};
    return a;
  endfunction

  function automatic logic [5:0] off_step(input logic [5:0] o, input logic left);
    if (left) return (o == 6'(LINE_LEN - 1)) ? 6'd0 : o + 6'd1;
    return (o == 6'd0) ? 6'(LINE_LEN - 1) : o - 6'd1;
  endfunction
endpackage

// File: rtl/chardisp_decode.sv
module chardisp_decode
  import chardisp_pkg::*;
(
  input  logic [7:0] code,
  output op_e        op
);
  always_comb begin
    priority casez (code)
      8'b1???????: op = OP_DDADDR;
      8'b01??????: op = OP_CGADDR;
      8'b001?????: op = OP_CONFIG;
      8'b0001????: op = OP_MOVE;
      8'b00001???: op = OP_DISP;
      8'b000001??: op = OP_ENTRY;
      8'b0000001?: op = OP_HOME;
      8'b00000001: op = OP_CLEAR;
      default:     op = OP_NONE;
    endcase
  end
endmodule

// File: rtl/chardisp_busy_timer.sv
module chardisp_busy_timer #(
  parameter int unsigned LONG_CYCLES  = 76000,
  parameter int unsigned SHORT_CYCLES = 1850
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic long_op,
  output logic busy
);
  localparam int unsigned CW = $clog2(LONG_CYCLES + 1);
  logic [CW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            left_q <= '0;
    else if (start)        left_q <= long_op ? CW'(LONG_CYCLES) : CW'(SHORT_CYCLES);
    else if (left_q != '0) left_q <= left_q - CW'(1);
  end

  assign busy = (left_q != '0);
endmodule

// File: rtl/chardisp_ctrl.sv
module chardisp_ctrl
  import chardisp_pkg::*;
#(
  parameter int unsigned LONG_CYCLES  = 76000,
  parameter int unsigned SHORT_CYCLES = 1850,
  parameter logic [7:0]  BLANK_CODE   = 8'h20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rs,
  input  logic       rw,
  input  logic       wr_strobe,
  input  logic       rd_strobe,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       busy,
  input  logic [6:0] view_addr,
  output logic [7:0] view_data,
  output logic       mode_incr,
  output logic       mode_autoshift,
  output logic       disp_on,
  output logic       cursor_on,
  output logic       blink_on,
  output logic       bus8,
  output logic       lines2,
  output logic       font_tall,
  output logic [5:0] disp_offset
);
  logic [7:0] dd_mem [DD_BYTES];
  logic [7:0] cg_mem [CG_BYTES];
  logic [6:0] ac_q;
  logic       cg_sel_q;
  logic [5:0] off_q;
  logic       incr_q, ashift_q, don_q, cur_q, blk_q, b8_q, l2_q, ft_q;
  logic [7:0] rdata_q;

  op_e  op;
  logic wr_ok, rdd_ok, stat_ok, long_op;
  logic [6:0] ac_up, ac_dn, ac_data_next;
  logic       cur_ok;
  logic [6:0] cur_idx;
  logic [7:0] cur_byte;

  chardisp_decode u_dec (.code(wdata), .op(op));

  assign wr_ok   = wr_strobe & ~rw & ~busy;
  assign rdd_ok  = rd_strobe &  rw &  rs & ~busy;
  assign stat_ok = rd_strobe &  rw & ~rs;
  assign long_op = wr_ok & ~rs & ((op == OP_CLEAR) | (op == OP_HOME));

  chardisp_busy_timer #(
    .LONG_CYCLES (LONG_CYCLES),
    .SHORT_CYCLES(SHORT_CYCLES)
  ) u_busy (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (wr_ok | rdd_ok),
    .long_op(long_op),
    .busy   (busy)
  );

  // Pointer stepping for whichever memory is selected.
  always_comb begin
    if (cg_sel_q) begin
      ac_up = {1'b0, ac_q[5:0] + 6'd1};
      ac_dn = {1'b0, ac_q[5:0] - 6'd1};
    end else begin
      ac_up = dd_next(ac_q, 1'b1, l2_q);
      ac_dn = dd_next(ac_q, 1'b0, l2_q);
    end
    ac_data_next = incr_q ? ac_up : ac_dn;
    cur_ok   = dd_ok(ac_q, l2_q);
    cur_idx  = dd_idx(ac_q, l2_q);
    cur_byte = cg_sel_q ? cg_mem[ac_q[5:0]] : (cur_ok ? dd_mem[cur_idx] : 8'h00);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(DD_BYTES); i++) dd_mem[i] <= BLANK_CODE;
      for (int i = 0; i < int'(CG_BYTES); i++) cg_mem[i] <= 8'h00;
      ac_q <= '0; cg_sel_q <= 1'b0; off_q <= '0; rdata_q <= '0;
      incr_q <= 1'b1; ashift_q <= 1'b0; don_q <= 1'b0; cur_q <= 1'b0;
      blk_q <= 1'b0; b8_q <= 1'b0; l2_q <= 1'b0; ft_q <= 1'b0;
    end else begin
      if (stat_ok) rdata_q <= {busy, ac_q};
      if (rdd_ok) begin
        rdata_q <= cur_byte;
        ac_q    <= ac_data_next;
      end
      if (wr_ok && rs) begin
        if (cg_sel_q) cg_mem[ac_q[5:0]] <= wdata;
        else begin
          if (cur_ok) dd_mem[cur_idx] <= wdata;
          if (ashift_q) off_q <= off_step(off_q, incr_q);
        end
        ac_q <= ac_data_next;
      end
      if (wr_ok && !rs) begin
        unique case (op)
          OP_CLEAR: begin
            for (int i = 0; i < int'(DD_BYTES); i++) dd_mem[i] <= BLANK_CODE;
            ac_q <= '0; incr_q <= 1'b1; off_q <= '0; cg_sel_q <= 1'b0;
          end
          OP_HOME:  begin ac_q <= '0; off_q <= '0; cg_sel_q <= 1'b0; end
          OP_ENTRY: begin incr_q <= wdata[1]; ashift_q <= wdata[0]; end
          OP_DISP:  begin don_q <= wdata[2]; cur_q <= wdata[1]; blk_q <= wdata[0]; end
          OP_MOVE: begin
            if (wdata[3]) off_q <= off_step(off_q, ~wdata[2]);
            else          ac_q  <= wdata[2] ? ac_up : ac_dn;
          end
          OP_CONFIG: begin b8_q <= wdata[4]; l2_q <= wdata[3]; ft_q <= wdata[2]; end
          OP_CGADDR: begin ac_q <= {1'b0, wdata[5:0]}; cg_sel_q <= 1'b1; end
          OP_DDADDR: begin ac_q <= wdata[6:0]; cg_sel_q <= 1'b0; end
          default: ;
        endcase
      end
    end
  end

  assign view_data = dd_ok(view_addr, l2_q) ? dd_mem[dd_idx(view_addr, l2_q)] : 8'h00;
  assign rdata          = rdata_q;
  assign mode_incr      = incr_q;
  assign mode_autoshift = ashift_q;
  assign disp_on        = don_q;
  assign cursor_on      = cur_q;
  assign blink_on       = blk_q;
  assign bus8           = b8_q;
  assign lines2         = l2_q;
  assign font_tall      = ft_q;
  assign disp_offset    = off_q;
endmodule

// File: rtl/chardisp_ctrl_chk.sv
module chardisp_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rs,
  input logic       rw,
  input logic       wr_strobe,
  input logic       rd_strobe,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       busy,
  input logic [6:0] ac_q,
  input logic [5:0] disp_offset
);
  AST_STATUS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe && rw && !rs |=> rdata == {$past(busy), $past(ac_q)}); // R1

  AST_STATUS_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && rd_strobe && rw && !rs && !wr_strobe |=> !busy); // R1

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && wr_strobe && !rw |=> busy); // R3

  AST_CLEAR_HOME_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && wr_strobe && !rw && !rs && wdata[7:2] == 6'd0 && wdata[1:0] != 2'd0
    |=> ac_q == 7'd0 && disp_offset == 6'd0); // R4

  AST_BUSY_DROPS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    busy && wr_strobe |=> ac_q == $past(ac_q)); // R8

  AST_READ_IDLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && wr_strobe && rw && !rd_strobe |=> !busy && ac_q == $past(ac_q)); // R12

  AST_OFFSET_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    disp_offset < 6'd40); // R10
endmodule

bind chardisp_ctrl chardisp_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rs         (rs),
  .rw         (rw),
  .wr_strobe  (wr_strobe),
  .rd_strobe  (rd_strobe),
  .wdata      (wdata),
  .rdata      (rdata),
  .busy       (busy),
  .ac_q       (ac_q),
  .disp_offset(disp_offset)
);

// File: tb/chardisp_ctrl_tb_top.sv
module chardisp_ctrl_tb_top;
  localparam int LONG  = 12;
  localparam int SHORT = 3;
  localparam logic [7:0] BLANK = 8'h20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rs = 1'b0, rw = 1'b0, wr_strobe = 1'b0, rd_strobe = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic busy;
  logic [6:0] view_addr = 7'h00;
  logic [7:0] view_data;
  logic mode_incr, mode_autoshift, disp_on, cursor_on, blink_on, bus8, lines2, font_tall;
  logic [5:0] disp_offset;

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;
  logic [7:0] exp_dd [128];

  always #10 clk = ~clk;

  chardisp_ctrl #(.LONG_CYCLES(LONG), .SHORT_CYCLES(SHORT), .BLANK_CODE(BLANK)) dut_i (
    .clk(clk), .rst_n(rst_n), .rs(rs), .rw(rw), .wr_strobe(wr_strobe),
    .rd_strobe(rd_strobe), .wdata(wdata), .rdata(rdata), .busy(busy),
    .view_addr(view_addr), .view_data(view_data), .mode_incr(mode_incr),
    .mode_autoshift(mode_autoshift), .disp_on(disp_on), .cursor_on(cursor_on),
    .blink_on(blink_on), .bus8(bus8), .lines2(lines2), .font_tall(font_tall),
    .disp_offset(disp_offset)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_wr(input logic r, input logic [7:0] d);
    @(negedge clk); rs = r; rw = 1'b0; wdata = d; wr_strobe = 1'b1;
    @(negedge clk); wr_strobe = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  task automatic wr(input logic r, input logic [7:0] d);
    int n;
    pulse_wr(r, d);
    wait_idle(n);
  endtask

  task automatic rd_status(output logic [7:0] v);
    @(negedge clk); rs = 1'b0; rw = 1'b1; rd_strobe = 1'b1;
    @(negedge clk); rd_strobe = 1'b0; rw = 1'b0; v = rdata;
  endtask

  task automatic rd_data(output logic [7:0] v, output int n);
    @(negedge clk); rs = 1'b1; rw = 1'b1; rd_strobe = 1'b1;
    @(negedge clk); rd_strobe = 1'b0; rw = 1'b0; v = rdata;
    wait_idle(n);
  endtask

  task automatic view(input logic [6:0] a, output logic [7:0] v);
    view_addr = a; #1; v = view_data;
  endtask

  function automatic int tb_next(input int a, input bit up, input bit two);
    if (two) begin
      if (up) return (a == 39) ? 64 : (a == 103) ? 0 : a + 1;
      return (a == 64) ? 39 : (a == 0) ? 103 : a - 1;
    end
    if (up) return (a == 79) ? 0 : a + 1;
    return (a == 0) ? 79 : a - 1;
  endfunction

  function automatic bit tb_valid(input int a, input bit two);
    if (two) return (a < 40) || (a >= 64 && a < 104);
    return a < 80;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int n, a;
    for (int i = 0; i < 128; i++) exp_dd[i] = BLANK;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R13 reset state
    check("R13 busy", busy, 0);
    check("R13 incr", mode_incr, 1);
    check("R13 disp_on", disp_on, 0);
    check("R13 offset", disp_offset, 0);
    view(7'h00, v); check("R13 text blank", v, BLANK);
    rd_status(v); check("R13 status", v, 8'h00);

    // R2 / R3 configuration with short busy
    pulse_wr(1'b0, 8'h38); wait_idle(n);
    check("R3 short busy", n, SHORT);
    check("R2 lines2", lines2, 1); check("R2 bus8", bus8, 1); check("R2 font", font_tall, 0);
    wr(1'b0, 8'h0F);
    check("R2 on", disp_on, 1); check("R2 cursor", cursor_on, 1); check("R2 blink", blink_on, 1);
    wr(1'b0, 8'h0C);
    check("R2 cursor off", cursor_on, 0); check("R2 blink off", blink_on, 0);
    wr(1'b0, 8'h3F); check("R2 top bit wins font", font_tall, 1);
    check("R2 top bit wins mode", mode_incr, 1);
    wr(1'b0, 8'h38);
    pulse_wr(1'b0, 8'h01); wait_idle(n); check("R3 clear long busy", n, LONG);
    pulse_wr(1'b0, 8'h03); wait_idle(n); check("R3 home long busy", n, LONG);

    // R6 two-line ring sweep
    wr(1'b0, 8'h80);
    a = 0;
    for (int k = 0; k < 80; k++) begin
      wr(1'b1, 8'(k + 8'h21));
      exp_dd[a] = 8'(k + 8'h21);
      a = tb_next(a, 1'b1, 1'b1);
      rd_status(v); check("R6 pointer after write", v, a);
    end
    for (int va = 0; va < 128; va++) begin
      view(7'(va), v);
      check("R6 view", v, tb_valid(va, 1'b1) ? exp_dd[va] : 8'h00);
    end
    wr(1'b0, 8'h04); check("R2 entry decrement", mode_incr, 0);
    wr(1'b0, 8'hC0); wr(1'b1, 8'hAA); exp_dd[64] = 8'hAA;
    rd_status(v); check("R6 down 0x40 to 0x27", v, 8'h27);
    wr(1'b0, 8'h80); wr(1'b1, 8'hBB); exp_dd[0] = 8'hBB;
    rd_status(v); check("R6 down 0x00 to 0x67", v, 8'h67);
    view(7'h40, v); check("R6 view 0x40", v, 8'hAA);
    view(7'h00, v); check("R6 view 0x00", v, 8'hBB);

    // R8 writes while busy
    wr(1'b0, 8'h06); wr(1'b0, 8'h85);
    pulse_wr(1'b1, 8'h11); pulse_wr(1'b1, 8'h22); wait_idle(n);
    exp_dd[5] = 8'h11;
    rd_status(v); check("R8 pointer", v, 8'h06);
    view(7'h05, v); check("R8 first kept", v, 8'h11);
    view(7'h06, v); check("R8 second dropped", v, exp_dd[6]);
    pulse_wr(1'b0, 8'h80); pulse_wr(1'b0, 8'h8A); wait_idle(n);
    rd_status(v); check("R8 command dropped", v, 8'h00);

    // R12 mismatched direction
    @(negedge clk); rs = 1'b0; rw = 1'b1; wdata = 8'h8A; wr_strobe = 1'b1;
    @(negedge clk); wr_strobe = 1'b0; rw = 1'b0;
    check("R12 no busy", busy, 0);
    rd_status(v); check("R12 pointer", v, 8'h00);
    @(negedge clk); rs = 1'b1; rw = 1'b0; rd_strobe = 1'b1;
    @(negedge clk); rd_strobe = 1'b0;
    check("R12 read ignored", busy, 0);

    // R1 status while busy
    pulse_wr(1'b0, 8'h85); rd_status(v); check("R1 busy status", v, 8'h85);
    wait_idle(n);
    rd_status(v); check("R1 idle status", v, 8'h05);
    check("R1 no busy from status", busy, 0);

    // R9 pattern memory
    wr(1'b0, 8'h7E);
    wr(1'b1, 8'h5A); rd_status(v); check("R9 cg step", v, 8'h3F);
    wr(1'b1, 8'h5B); rd_status(v); check("R9 cg wrap", v, 8'h00);
    wr(1'b1, 8'h5C); rd_status(v); check("R9 cg after wrap", v, 8'h01);
    view(7'h00, v); check("R9 text untouched", v, 8'hBB);
    view(7'h01, v); check("R9 text untouched 1", v, exp_dd[1]);
    wr(1'b0, 8'h7E);
    rd_data(v, n); check("R9 cg read 0", v, 8'h5A); check("R3 read busy", n, SHORT);
    rd_data(v, n); check("R9 cg read 1", v, 8'h5B);
    rd_data(v, n); check("R9 cg read 2", v, 8'h5C);
    wr(1'b0, 8'h80);
    rd_data(v, n); check("R9 text read", v, 8'hBB);
    rd_status(v); check("R9 text read step", v, 8'h01);

    // R10 shift and cursor move
    wr(1'b0, 8'h18); check("R10 left", disp_offset, 1);
    wr(1'b0, 8'h1C); check("R10 right", disp_offset, 0);
    wr(1'b0, 8'h1C); check("R10 right wrap", disp_offset, 39);
    wr(1'b0, 8'h18); check("R10 left wrap", disp_offset, 0);
    wr(1'b0, 8'hA7); wr(1'b0, 8'h14);
    rd_status(v); check("R10 cursor right", v, 8'h40);
    wr(1'b0, 8'h10);
    rd_status(v); check("R10 cursor left", v, 8'h27);
    view(7'h27, v); check("R10 no memory change", v, exp_dd[39]);

    // R11 auto-shift
    wr(1'b0, 8'h07); wr(1'b0, 8'h80); wr(1'b1, 8'h44); exp_dd[0] = 8'h44;
    check("R11 shift up", disp_offset, 1);
    wr(1'b0, 8'h05); wr(1'b1, 8'h45); exp_dd[1] = 8'h45;
    check("R11 shift down", disp_offset, 0);

    // R5 home
    wr(1'b0, 8'h18); wr(1'b0, 8'h85); wr(1'b0, 8'h02);
    rd_status(v); check("R5 pointer", v, 8'h00);
    check("R5 offset", disp_offset, 0);
    view(7'h00, v); check("R5 memory kept", v, 8'h44);
    check("R5 incr kept", mode_incr, 0);

    // R4 clear
    wr(1'b0, 8'h18); wr(1'b0, 8'h01);
    rd_status(v); check("R4 pointer", v, 8'h00);
    check("R4 incr forced", mode_incr, 1);
    check("R4 offset", disp_offset, 0);
    for (int va = 0; va < 128; va++) begin
      view(7'(va), v);
      check("R4 blank", v, tb_valid(va, 1'b1) ? BLANK : 8'h00);
    end

    // R7 one-line
    wr(1'b0, 8'h30); check("R7 lines2 off", lines2, 0);
    wr(1'b0, 8'hCF); wr(1'b1, 8'h61);
    rd_status(v); check("R7 up wrap", v, 8'h00);
    view(7'h4F, v); check("R7 view 0x4F", v, 8'h61);
    wr(1'b0, 8'h04); wr(1'b1, 8'h62);
    rd_status(v); check("R7 down wrap", v, 8'h4F);
    view(7'h00, v); check("R7 view 0x00", v, 8'h62);
    view(7'h50, v); check("R7 out of range", v, 8'h00);
    view(7'h45, v); check("R7 flat index", v, BLANK);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule